// File: doc/BRIEF.md
# Canonical-signed-digit constant multiplier

This block multiplies an unsigned operand by a constant fixed when the design is elaborated. No general multiplier array is built. When the design is elaborated, the constant is rewritten as a string of digits drawn from {-1, 0, +1} in which no two nonzero digits sit next to each other. Each nonzero digit then becomes one copy of the operand, moved left by the digit's position. Each copy is either added or subtracted. Because the moves are fixed, they are pure wiring, and the arithmetic left over is a small tree of adders.

The product is full width: operand width plus constant width. An unsigned product cannot overflow that width. An optional output register samples the product whenever the input strobe is high, and it delays the strobe by one cycle. With the register left out, the block is purely combinational from operand to product.

Top module: `csd_const_mult`

## Requirements
- R1: For every operand, out_prod equals the exact product in_data × COEF, computed in IN_W+COEF_W bits.
- R2: With REG_OUT=1, an operand sampled while in_valid is high appears on out_prod one clock later, and out_valid equals the value in_valid had one clock earlier.
- R3: With REG_OUT=1, while rst_n is low, out_valid is 0 and out_prod is 0.
- R4: With REG_OUT=1, a clock edge with in_valid low leaves out_prod unchanged, whatever in_data holds.
- R5: For COEF=111 (binary 0110_1111), the product equals (X<<7) − (X<<4) − X for every operand X.
- R6: For a constant made entirely of ones (COEF = 2^COEF_W − 1), the product equals (X<<COEF_W) − X for every operand X.
- R7: For a constant with no two adjacent one bits (COEF=85, binary 0101_0101), the product is exact for every operand.
- R8: The operand boundary values 0 and 2^IN_W − 1 give products of exactly 0 and (2^IN_W − 1) × COEF.
- R9: With REG_OUT=0, out_prod equals in_data × COEF in the same cycle, and out_valid equals in_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Strobe that marks in_data as a new operand |
| in_data | input | IN_W | Unsigned operand |
| out_valid | output | 1 | Strobe that marks out_prod as a new product |
| out_prod | output | IN_W+COEF_W | Full-width unsigned product |

## Verification
Suppose a digit is recoded with the wrong sign or at the wrong position. The product is then off by a fixed multiple of a power of two of the operand, so it is wrong for almost every nonzero operand. With the register present, the error shows one clock after the operand is strobed; without it, the error shows at once. A fault in the adder tree or in the two's-complement handling shows most clearly on the all-ones operand and the all-ones constant, where every bit carries. A fault in the register enable shows as a product that changes on a cycle with no strobe.

// File: rtl/csd_pkg.sv
package csd_pkg;

  // Recode c into non-adjacent signed digits.
  // want_neg=0 returns the mask of +1 digits; want_neg=1 returns the mask of -1 digits.
  function automatic logic [63:0] csd_recode(input logic [63:0] c, input logic want_neg);
    logic [64:0] x;
    logic [63:0] pos;
    logic [63:0] neg;
    x   = {1'b0, c};
    pos = '0;
    neg = '0;
    for (int i = 0; i < 64; i++) begin
      if (x[0]) begin
        if (x[1]) begin
          neg[i] = 1'b1;
          x      = x + 65'd1;
        end else begin
          pos[i] = 1'b1;
          x      = x - 65'd1;
        end
      end
      x = x >> 1;
    end
    return want_neg ? neg : pos;
  endfunction

  // Number of nonzero digits in the recoded constant.
  function automatic int csd_weight(input logic [63:0] c);
    logic [63:0] m;
    int n;
    m = csd_recode(c, 1'b0) | csd_recode(c, 1'b1);
    n = 0;
    for (int i = 0; i < 64; i++) n += int'(m[i]);
    return n;
  endfunction

endpackage

// File: rtl/csd_shift_bank.sv
module csd_shift_bank #(
  parameter int IN_W = 8,
  parameter int P_W  = 16,
  parameter int NDIG = 9,
  parameter logic [NDIG-1:0] POS_MASK = '0,
  parameter logic [NDIG-1:0] NEG_MASK = '0
) (
  input  logic [IN_W-1:0]           x,
  output logic [NDIG-1:0][P_W-1:0]  terms
);
  logic [P_W-1:0] x_ext;
  assign x_ext = {{(P_W-IN_W){1'b0}}, x};

  for (genvar i = 0; i < NDIG; i++) begin : g_dig
    if (POS_MASK[i]) begin : g_add
      assign terms[i] = x_ext << i;
    end else if (NEG_MASK[i]) begin : g_sub
      assign terms[i] = (~(x_ext << i)) + P_W'(1);
    end else begin : g_zero
      assign terms[i] = '0;
    end
  end
endmodule

// File: rtl/csd_sum_tree.sv
module csd_sum_tree #(
  parameter int P_W  = 16,
  parameter int NDIG = 9
) (
  input  logic [NDIG-1:0][P_W-1:0] terms,
  output logic [P_W-1:0]           sum
);
  localparam int NLEV = (NDIG > 1) ? $clog2(NDIG) : 1;
  localparam int NPAD = 1 << NLEV;
  localparam int NNODE = 2 * NPAD - 1;

  logic [P_W-1:0] node [NNODE];

  for (genvar k = 0; k < NPAD; k++) begin : g_leaf
    if (k < NDIG) begin : g_real
      assign node[NPAD-1+k] = terms[k];
    end else begin : g_pad
      assign node[NPAD-1+k] = '0;
    end
  end

  for (genvar k = 0; k < NPAD - 1; k++) begin : g_add
    assign node[k] = node[2*k+1] + node[2*k+2];
  end

  assign sum = node[0];
endmodule

// File: rtl/csd_out_stage.sv
module csd_out_stage #(
  parameter int P_W     = 16,
  parameter bit REG_OUT = 1'b1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [P_W-1:0] prod_in,
  output logic           out_valid,
  output logic [P_W-1:0] out_prod
);
  if (REG_OUT) begin : g_reg
    logic           load_fire;
    logic           v_q;
    logic [P_W-1:0] p_q;

    assign load_fire = in_valid;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        p_q <= '0;
      end else begin
        v_q <= in_valid;
        if (load_fire) p_q <= prod_in;
      end
    end

    assign out_valid = v_q;
    assign out_prod  = p_q;

    // R2
    valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
    // R2
    valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
    // R4
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(out_prod));
  end else begin : g_comb
    assign out_valid = in_valid;
    assign out_prod  = prod_in;
  end
endmodule

// File: rtl/csd_const_mult.sv
module csd_const_mult #(
  parameter int          IN_W    = 8,
  parameter int          COEF_W  = 8,
  parameter int unsigned COEF    = 111,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [IN_W-1:0]          in_data,
  output logic                     out_valid,
  output logic [IN_W+COEF_W-1:0]   out_prod
);
  localparam int P_W  = IN_W + COEF_W;
  localparam int NDIG = COEF_W + 1;
  localparam logic [63:0] COEF64   = 64'(COEF);
  localparam logic [63:0] POS_ALL  = csd_pkg::csd_recode(COEF64, 1'b0);
  localparam logic [63:0] NEG_ALL  = csd_pkg::csd_recode(COEF64, 1'b1);
  localparam logic [NDIG-1:0] POS_MASK = POS_ALL[NDIG-1:0];
  localparam logic [NDIG-1:0] NEG_MASK = NEG_ALL[NDIG-1:0];
  localparam int NONZERO = csd_pkg::csd_weight(COEF64);

  logic [NDIG-1:0][P_W-1:0] terms;
  logic [P_W-1:0]           comb_prod;

  csd_shift_bank #(
    .IN_W(IN_W), .P_W(P_W), .NDIG(NDIG),
    .POS_MASK(POS_MASK), .NEG_MASK(NEG_MASK)
  ) u_bank (
    .x(in_data),
    .terms(terms)
  );

  csd_sum_tree #(.P_W(P_W), .NDIG(NDIG)) u_tree (
    .terms(terms),
    .sum(comb_prod)
  );

  csd_out_stage #(.P_W(P_W), .REG_OUT(REG_OUT)) u_out (
    .clk(clk),
    .rst_n(rst_n),
    .in_valid(in_valid),
    .prod_in(comb_prod),
    .out_valid(out_valid),
    .out_prod(out_prod)
  );

  if (REG_OUT) begin : g_chk
    logic [P_W-1:0] ref_prod;
    assign ref_prod = P_W'(in_data) * P_W'(COEF);
    // R1
    prod_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (out_prod == $past(ref_prod)));
  end

  initial begin
    // R1
    digit_budget_chk: assert (NONZERO <= (NDIG + 1) / 2)
      else $error("recoded constant exceeds half nonzero digits");
  end
endmodule

// File: tb/sim_csd_const_mult.sv
module sim_csd_const_mult;
  localparam int W = 8;
  localparam int PW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [W-1:0] in_data = '0;

  logic a_v, b_v, c_v, d_v;
  logic [PW-1:0] a_p, b_p, c_p, d_p;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [PW-1:0] hold_a, hold_b, hold_c;

  always #10 clk = ~clk;

  csd_const_mult #(.IN_W(W), .COEF_W(8), .COEF(111), .REG_OUT(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(a_v), .out_prod(a_p));
  csd_const_mult #(.IN_W(W), .COEF_W(8), .COEF(85), .REG_OUT(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(b_v), .out_prod(b_p));
  csd_const_mult #(.IN_W(W), .COEF_W(8), .COEF(255), .REG_OUT(1'b1)) u2 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(c_v), .out_prod(c_p));
  csd_const_mult #(.IN_W(W), .COEF_W(8), .COEF(111), .REG_OUT(1'b0)) u3 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(d_v), .out_prod(d_p));

  function automatic logic [PW-1:0] mul_ref(input logic [W-1:0] x, input int c);
    return PW'(x) * PW'(c);
  endfunction

  function automatic logic [PW-1:0] form_111(input logic [W-1:0] x);
    logic [PW-1:0] e;
    e = PW'(x);
    return (e << 7) - (e << 4) - e;
  endfunction

  function automatic logic [PW-1:0] form_ones(input logic [W-1:0] x);
    logic [PW-1:0] e;
    e = PW'(x);
    return (e << 8) - e;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic [W-1:0] x, input logic v);
    @(negedge clk);
    in_data  = x;
    in_valid = v;
    #1;
    chk("R9 comb product", 32'(d_p), 32'(mul_ref(x, 111)));
    chk("R9 comb valid", 32'(d_v), 32'(v));
    if (v) begin
      hold_a = form_111(x);
      hold_b = mul_ref(x, 85);
      hold_c = form_ones(x);
    end
    @(posedge clk);
    #1;
    chk("R2 valid delay", 32'(a_v), 32'(v));
    if (v) begin
      chk("R1 R5 product 111", 32'(a_p), 32'(hold_a));
      chk("R7 product 85", 32'(b_p), 32'(hold_b));
      chk("R6 product 255", 32'(c_p), 32'(hold_c));
    end else begin
      chk("R4 hold 111", 32'(a_p), 32'(hold_a));
      chk("R4 hold 85", 32'(b_p), 32'(hold_b));
      chk("R4 hold 255", 32'(c_p), 32'(hold_c));
    end
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    hold_a = '0;
    hold_b = '0;
    hold_c = '0;
    seed = $urandom(32'h5eed_c5d1);
    repeat (3) @(negedge clk);
    // R3: reset state of registered outputs
    chk("R3 valid in reset", 32'(a_v), 32'd0);
    chk("R3 product in reset", 32'(a_p), 32'd0);
    chk("R3 product in reset 255", 32'(c_p), 32'd0);
    rst_n = 1'b1;

    // R8: operand boundaries
    step(8'h00, 1'b1);
    step(8'hFF, 1'b1);
    chk("R8 all-ones operand x111", 32'(a_p), 32'd28305);
    chk("R8 all-ones operand x255", 32'(c_p), 32'd65025);
    step(8'h00, 1'b1);
    chk("R8 zero operand", 32'(a_p), 32'd0);
    // R4: idle cycles with changing data keep the last product
    step(8'hFF, 1'b1);
    step(8'h12, 1'b0);
    step(8'h34, 1'b0);
    chk("R4 still all-ones x85", 32'(b_p), 32'd21675);
    step(8'h01, 1'b1);
    step(8'h80, 1'b1);

    for (int n = 0; n < 300; n++) begin
      logic [W-1:0] r;
      logic vv;
      r  = W'($urandom);
      vv = ($urandom % 4) != 0;
      step(r, vv);
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule